// File: doc/BRIEF.md
# Packed Word Byte Unpacker

This block takes 32-bit packed words from an upstream valid/ready source and expands each one into a stream of one to four bytes. The bytes leave on a valid/ready byte port with the lowest byte first. The upper byte lanes of a word tell how many bytes it carries. A run of fixed marker values in the top lanes means that fewer bytes are present. Any word whose top lanes match no marker carries four raw data bytes.

A single holding register keeps the current word. A new word is taken only after every byte of the held word has been handed off, so the consumer's backpressure reaches the word source directly. Each output byte comes with a flag that marks the final byte of its word. The consumer, or a checker, can use that flag to find word boundaries.

Top module: `word_unpacker`

## Requirements
- R1: A word whose bits 31:8 equal 0x808080 yields exactly one byte, taken from bits 7:0.
- R2: A word whose bits 31:16 equal 0x8181 and that does not satisfy R1 yields two bytes: bits 7:0 first, then bits 15:8.
- R3: A word whose bits 31:24 equal 0x82 and that satisfies neither R1 nor R2 yields three bytes: bits 7:0, then 15:8, then 23:16.
- R4: Every other word yields four bytes. This includes words that come close to a marker pattern without matching it.
- R5: Bytes leave in ascending lane order, and the first byte is on `outByte` in the cycle after the word is accepted.
- R6: `outLast` is high on the final byte of each word and low on every earlier byte of that word.
- R7: `inWordReady` is low while any byte of the held word remains unsent. A word offered during that time is not taken and does not change the bytes being sent.
- R8: While `outByteValid` is high and `outByteReady` is low, `outByteValid`, `outByte` and `outLast` hold their values.
- R9: After reset, `outByteValid` is low and `inWordReady` is high.
- R10: In the cycle after the final byte of a word is accepted, `outByteValid` is low and `inWordReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inWordValid | input | 1 | Upstream offers a packed word |
| inWordReady | output | 1 | Block is idle and can take a word |
| inWord | input | 32 | Packed word |
| outByteValid | output | 1 | A byte is presented |
| outByteReady | input | 1 | Consumer takes the presented byte |
| outByte | output | 8 | Current byte |
| outLast | output | 1 | Current byte is the last of its word |

## Verification
If the stored byte count is wrong, the word gets cut short or padded. That shows at the ports as `outLast` on the wrong byte, or as extra bytes, on the first word of the affected length. If the lane index is wrong, the wrong byte appears on the very first or second handshake. If the busy flag is stuck, `inWordReady` shows the fault in the cycle after a word is taken or after its last byte leaves. A lost hold under backpressure changes `outByte` one cycle into a stall.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new word
    logic step;   // current byte handed off, move to next lane
  } unpackStrobe_t;
endpackage

// File: rtl/unpack_dpath.sv
module unpack_dpath
  import unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int MARK_BASE = 8'h80
) (
  input  logic                clk,
  input  logic                rstN,
  input  unpackStrobe_t       strobe,
  input  logic [WORD_W-1:0]   inWord,
  output logic [BYTE_W-1:0]   outByte,
  output logic                lastLane
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IDX_W = $clog2(LANES);

  logic [LANES-1:1]  shortHit;
  logic [IDX_W-1:0]  newLast;
  logic [WORD_W-1:0] holdWord;
  logic [IDX_W-1:0]  lastIdx;
  logic [IDX_W-1:0]  curIdx;

  // one marker test per short length k: top LANES-k lanes equal MARK_BASE+k-1
  for (genvar k = 1; k < LANES; k++) begin : g_mark
    localparam logic [BYTE_W-1:0] MK = BYTE_W'(MARK_BASE + k - 1);
    assign shortHit[k] = (inWord[WORD_W-1:k*BYTE_W] == {(LANES-k){MK}});
  end

  // shortest length wins; raw full word when nothing matches
  always_comb begin
    newLast = IDX_W'(LANES - 1);
    for (int k = LANES - 1; k >= 1; k--) begin
      if (shortHit[k]) newLast = IDX_W'(k - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdWord <= '0;
      lastIdx  <= '0;
      curIdx   <= '0;
    end else if (strobe.load) begin
      holdWord <= inWord;
      lastIdx  <= newLast;
      curIdx   <= '0;
    end else if (strobe.step) begin
      curIdx   <= curIdx + 1'b1;
    end
  end

  assign outByte  = holdWord[curIdx*BYTE_W +: BYTE_W];
  assign lastLane = (curIdx == lastIdx);

  AST_ONE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && (inWord[WORD_W-1:BYTE_W] == {(LANES-1){BYTE_W'(MARK_BASE)}})
    |=> lastLane); // R1

  AST_FIRST_LANE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (outByte == $past(inWord[BYTE_W-1:0]))); // R5
endmodule

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          outReady,
  input  logic          lastLane,
  output logic          inReady,
  output logic          outValid,
  output unpackStrobe_t strobe
);
  logic busy;

  assign inReady     = !busy;
  assign outValid    = busy;
  assign strobe.load = inValid && !busy;
  assign strobe.step = busy && outReady;

  always_ff @(posedge clk) begin
    if (!rstN)                          busy <= 1'b0;
    else if (strobe.load)               busy <= 1'b1;
    else if (strobe.step && lastLane)   busy <= 1'b0;
  end

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (outValid && !inReady)); // R7

  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid); // R8

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && lastLane) |=> (inReady && !outValid)); // R10
endmodule

// File: rtl/word_unpacker.sv
module word_unpacker
  import unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inWordValid,
  output logic              inWordReady,
  input  logic [WORD_W-1:0] inWord,
  output logic              outByteValid,
  input  logic              outByteReady,
  output logic [BYTE_W-1:0] outByte,
  output logic              outLast
);
  unpackStrobe_t strobe;
  logic          lastLane;

  unpack_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inWordValid),
    .outReady (outByteReady),
    .lastLane (lastLane),
    .inReady  (inWordReady),
    .outValid (outByteValid),
    .strobe   (strobe)
  );

  unpack_dpath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inWord   (inWord),
    .outByte  (outByte),
    .lastLane (lastLane)
  );

  assign outLast = outByteValid && lastLane;

  AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outByteValid && !outByteReady) |=> ($stable(outByte) && $stable(outLast))); // R8

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    inWordReady |-> !outByteValid); // R7
endmodule

// File: tb/test_word_unpacker.sv
module test_word_unpacker;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inWordValid;
  logic        inWordReady;
  logic [31:0] inWord;
  logic        outByteValid;
  logic        outByteReady;
  logic [7:0]  outByte;
  logic        outLast;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  word_unpacker i_word_unpacker (
    .clk(clk), .rstN(rstN),
    .inWordValid(inWordValid), .inWordReady(inWordReady), .inWord(inWord),
    .outByteValid(outByteValid), .outByteReady(outByteReady),
    .outByte(outByte), .outLast(outLast)
  );

  localparam int NV = 10;
  localparam logic [31:0] VEC_WORD [NV] = '{
    32'h80808041, 32'h80808080, 32'h81814342, 32'h81818181, 32'h82464544,
    32'h82818080, 32'h44434241, 32'h80808180, 32'h81808080, 32'h83000000};
  localparam int VEC_CNT [NV] = '{1, 1, 2, 2, 3, 3, 4, 4, 4, 4};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string lenTag(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      default: return "R4";
    endcase
  endfunction

  // offer a word while idle; called at a negedge, returns at a negedge
  task automatic offer(input logic [31:0] w);
    check(inWordReady == 1'b1, "R10 idle before offer", inWordReady, 1);
    inWordValid = 1'b1;
    inWord      = w;
    @(negedge clk);
    inWordValid = 1'b0;
    inWord      = 32'hDEADBEEF;
  endtask

  // drain n bytes of w, stalling where stallSel picks
  task automatic drain(input logic [31:0] w, input int n, input int stallSel);
    for (int k = 0; k < n; k++) begin
      logic [7:0] expB;
      expB = w[k*8 +: 8];
      if (((stallSel + k) % 3) == 0) begin
        outByteReady = 1'b0;
        @(negedge clk);
        check(outByteValid && outByte == expB, "R8 hold under stall", outByte, expB);
      end
      check(outByteValid == 1'b1, "R5 byte valid", outByteValid, 1);
      check(outByte == expB, "R5 lane order", outByte, expB);
      check(outLast == (k == n - 1), {lenTag(n), " R6 last flag"}, outLast, (k == n - 1));
      outByteReady = 1'b1;
      @(negedge clk);
    end
    outByteReady = 1'b0;
    check(outByteValid == 1'b0, {lenTag(n), " R10 no extra byte"}, outByteValid, 0);
    check(inWordReady == 1'b1, "R10 ready after last", inWordReady, 1);
  endtask

  initial begin
    rstN = 1'b0; inWordValid = 1'b0; inWord = '0; outByteReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(outByteValid == 1'b0, "R9 no byte after reset", outByteValid, 0);
    check(inWordReady == 1'b1, "R9 ready after reset", inWordReady, 1);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      offer(VEC_WORD[v]);
      drain(VEC_WORD[v], VEC_CNT[v], v);
    end

    // R7: a word offered while busy is not taken
    offer(32'h81812211);
    for (int c = 0; c < 3; c++) begin
      inWordValid = 1'b1;
      inWord      = 32'h80808099;
      @(negedge clk);
      check(inWordReady == 1'b0, "R7 not ready while busy", inWordReady, 0);
    end
    outByteReady = 1'b1;
    check(outByte == 8'h11, "R7 first byte kept", outByte, 8'h11);
    @(negedge clk);
    inWordValid = 1'b0;
    check(outByte == 8'h22 && outLast, "R7 second byte kept", outByte, 8'h22);
    @(negedge clk);
    outByteReady = 1'b0;
    check(outByteValid == 1'b0, "R7 offered word not taken", outByteValid, 0);

    // back-to-back words with ready held high: one idle cycle between words
    outByteReady = 1'b1;
    inWordValid  = 1'b1;
    inWord       = 32'h80808077;
    @(negedge clk);
    inWord       = 32'h04030201;
    check(outByte == 8'h77 && outLast, "R1 back-to-back single", outByte, 8'h77);
    @(negedge clk);
    check(outByteValid == 1'b0 && inWordReady, "R10 gap cycle", outByteValid, 0);
    @(negedge clk);
    inWordValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(outByte == 8'(k + 1) && outLast == (k == 3), "R4 back-to-back full", outByte, k + 1);
      @(negedge clk);
    end
    outByteReady = 1'b0;

    // reset while busy
    offer(32'h11223344);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outByteValid == 1'b0 && inWordReady, "R9 reset while busy", outByteValid, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule